// File: doc/BRIEF.md
# EEPROM Write Protection Unit

This block keeps the status register of a small serial EEPROM and decides whether a write to the array or to the status register may start. It holds a write-in-progress flag, a write-enable latch and a two-bit block-protect code. The command engine around it sends one-cycle event pulses when a frame completes: write-enable, write-disable, status-register write, and array write. The memory core sends a pulse when its self-timed cycle is done. The block also sees the hardware write-protect pin and the target address of the array write under consideration.

Two combinational outputs tell the command engine whether an array write at the presented address, or a status-register write, would be accepted now. A request pulse that arrives while the matching allow output is high starts a cycle: the busy flag rises on the next clock. It falls when the done pulse arrives, and the write-enable latch clears at the same moment. A status-register write keeps its new protect code pending and commits it when the cycle finishes. The non-volatile protect bits are modelled as plain registers. The serial interface is not part of this block.

All control pins are plain level or pulse signals. No data stream crosses the block edge, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset the status byte is 0x00 and neither write is allowed.
- R2: Status byte layout: bit 0 is the busy (write-in-progress) flag, bit 1 is the write-enable latch, bits 3:2 are the protect code, and bits 7:4 read as 0.
- R3: A write-enable pulse with the write-protect pin high sets the latch one clock later, whatever the protect code is. A write-disable pulse clears the latch.
- R4: While the write-protect pin (wp_n) is low, both allow outputs are 0. One clock after any cycle in which wp_n is low, the latch reads 0, even if a write-enable pulse arrived.
- R5: With the latch set and the pin high, an array write at address A is denied when A lies in the protected range. Code 00 protects nothing, 01 protects 0x180-0x1FF, 10 protects 0x100-0x1FF and 11 protects 0x000-0x1FF. Any protect code still allows a status-register write.
- R6: With the pin high and the latch clear, both allow outputs are 0.
- R7: An accepted request sets the busy flag on the next clock. While the busy flag is set, both allow outputs are 0 and further requests are ignored.
- R8: A done pulse while busy clears the busy flag and the latch on the next clock. A denied request leaves the latch unchanged.
- R9: A status-register write takes only bits 3:2 of its data as the new protect code and ignores the other bits. The old code stays visible until the done pulse, and the new code is visible one clock after it.
- R10: A write-protect pin falling during a cycle does not stop it. The busy flag stays set until the done pulse, and a pending protect code is still committed.
- R11: A write-enable pulse in the same clock as a write request does not enable that request. The request is judged on the latch value before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up state) |
| wp_n | input | 1 | Write-protect pin, low blocks all writes |
| wren_evt | input | 1 | Write-enable frame completed |
| wrdi_evt | input | 1 | Write-disable frame completed |
| sr_req | input | 1 | Status-register write frame completed |
| sr_wdata | input | 8 | Data byte of the status-register write |
| arr_req | input | 1 | Array write frame completed |
| arr_addr | input | 9 | Target address of the array write |
| cycle_done | input | 1 | Self-timed write cycle finished |
| status_byte | output | 8 | Status byte for the status read |
| arr_wr_ok | output | 1 | An array write at arr_addr would be accepted now |
| sr_wr_ok | output | 1 | A status-register write would be accepted now |

## Verification
The allow decision is probed with addresses just below and just above each quarter boundary, under all four protect codes. A wrong comparison threshold or an off-by-one range shows up at once. The bench tries the same requests with the latch clear, with the pin low, and while a cycle is busy, which shows that each of the three gates blocks writes on its own. Status writes with data bits set outside bits 3:2, a pin drop in mid-cycle, and a write-enable in the same clock as a request show apart the commit timing of the protect code, the independence of a running cycle from the pin, and the use of the registered latch value.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int ST_W      = 8;
  localparam int ST_WIP    = 0;
  localparam int ST_WEL    = 1;
  localparam int ST_BP_LO  = 2;
  localparam int BP_W      = 2;

  typedef logic [BP_W-1:0] bp_t;

  function automatic logic [ST_W-1:0] pack_status(input logic wip, input logic wel, input bp_t bp);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_WIP] = wip;
    s[ST_WEL] = wel;
    s[ST_BP_LO +: BP_W] = bp;
    return s;
  endfunction
endpackage

// File: rtl/wpg_region.sv
module wpg_region
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  bp_t               bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [1:0] quarter;
  assign quarter = addr[ADDR_W-1 -: 2];

  always_comb begin
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (quarter == 2'b11);
      2'b10:   hit = quarter[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpg_enable_latch.sv
module wpg_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic cycle_end,
  output logic wel
);
  logic wel_nxt;

  always_comb begin
    wel_nxt = wel;
    if (set_evt) wel_nxt = 1'b1;
    if (clr_evt || cycle_end || !wp_n) wel_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else        wel <= wel_nxt;
  end
endmodule

// File: rtl/wpg_cycle.sv
module wpg_cycle
  import wpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_arr,
  input  logic start_sr,
  input  bp_t  sr_bp_in,
  input  logic done,
  output logic wip,
  output logic cycle_end,
  output bp_t  bp
);
  logic pend_sr;
  bp_t  pend_bp;

  assign cycle_end = wip && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip     <= 1'b0;
      pend_sr <= 1'b0;
      pend_bp <= '0;
      bp      <= '0;
    end else if (cycle_end) begin
      wip     <= 1'b0;
      pend_sr <= 1'b0;
      if (pend_sr) bp <= pend_bp;
    end else if (!wip && (start_arr || start_sr)) begin
      wip     <= 1'b1;
      pend_sr <= start_sr && !start_arr;
      pend_bp <= sr_bp_in;
    end
  end
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wren_evt,
  input  logic              wrdi_evt,
  input  logic              sr_req,
  input  logic [ST_W-1:0]   sr_wdata,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              cycle_done,
  output logic [ST_W-1:0]   status_byte,
  output logic              arr_wr_ok,
  output logic              sr_wr_ok
);
  logic wel, wip, cycle_end, prot_hit, gate_open, arr_go, sr_go;
  bp_t  bp;

  wpg_region #(.ADDR_W(ADDR_W)) u_region (
    .bp   (bp),
    .addr (arr_addr),
    .hit  (prot_hit)
  );

  wpg_enable_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .set_evt   (wren_evt),
    .clr_evt   (wrdi_evt),
    .cycle_end (cycle_end),
    .wel       (wel)
  );

  // Registered latch value is used: a same-clock enable pulse cannot open the gate
  assign gate_open = wp_n && wel && !wip;
  assign arr_wr_ok = gate_open && !prot_hit;
  assign sr_wr_ok  = gate_open;
  assign arr_go    = arr_req && arr_wr_ok;
  assign sr_go     = sr_req && sr_wr_ok && !arr_req;

  wpg_cycle u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_arr (arr_go),
    .start_sr  (sr_go),
    .sr_bp_in  (sr_wdata[ST_BP_LO +: BP_W]),
    .done      (cycle_done),
    .wip       (wip),
    .cycle_end (cycle_end),
    .bp        (bp)
  );

  assign status_byte = pack_status(wip, wel, bp);
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       wren_evt,
  input logic       arr_req,
  input logic       arr_wr_ok,
  input logic       cycle_done,
  input logic [7:0] status_byte
);
  AST_ACCEPT_SETS_WIP: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && arr_wr_ok) |=> status_byte[0]); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_done && status_byte[0]) |=> (!status_byte[0] && !status_byte[1])); // R8
  AST_WP_LOW_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !status_byte[1]); // R4
  AST_WEL_RISE_NEEDS_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_byte[1]) |-> $past(wren_evt)); // R3
  AST_BP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cycle_done && status_byte[0]) |=> $stable(status_byte[3:2])); // R9
endmodule

bind nvm_write_guard wpg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wp_n        (wp_n),
  .wren_evt    (wren_evt),
  .arr_req     (arr_req),
  .arr_wr_ok   (arr_wr_ok),
  .cycle_done  (cycle_done),
  .status_byte (status_byte)
);

// File: tb/sim_nvm_write_guard.sv
`timescale 1ns/1ps
module sim_nvm_write_guard;
  logic clk = 0, rst_n = 0, wp_n = 1;
  logic wren_evt = 0, wrdi_evt = 0, sr_req = 0, arr_req = 0, cycle_done = 0;
  logic [7:0] sr_wdata = '0;
  logic [8:0] arr_addr = '0;
  logic [7:0] status_byte;
  logic arr_wr_ok, sr_wr_ok;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nvm_write_guard u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wren();  @(negedge clk) wren_evt = 1; @(negedge clk) wren_evt = 0; endtask
  task automatic do_wrdi();  @(negedge clk) wrdi_evt = 1; @(negedge clk) wrdi_evt = 0; endtask
  task automatic do_done();  @(negedge clk) cycle_done = 1; @(negedge clk) cycle_done = 0; endtask
  task automatic do_sr(input logic [7:0] d);
    @(negedge clk) sr_wdata = d; sr_req = 1; @(negedge clk) sr_req = 0;
  endtask
  task automatic do_arr(input logic [8:0] a);
    @(negedge clk) arr_addr = a; arr_req = 1; @(negedge clk) arr_req = 0;
  endtask
  task automatic set_bp(input logic [7:0] d);
    do_wren(); do_sr(d); do_done();
  endtask
  task automatic probe(input logic [8:0] a, input logic exp, input string tag);
    @(negedge clk) arr_addr = a; #1 chk(tag, {7'd0, arr_wr_ok}, {7'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status_byte, 8'h00);
    chk("R1 sr_ok after reset", {7'd0, sr_wr_ok}, 8'h00);
    chk("R6 arr_ok with latch clear", {7'd0, arr_wr_ok}, 8'h00);
  endtask

  task automatic t_latch();
    do_wren(); chk("R3 R2 wren sets latch bit1", status_byte, 8'h02);
    do_wrdi(); chk("R3 wrdi clears latch", status_byte, 8'h00);
    #1 chk("R6 sr_ok with latch clear", {7'd0, sr_wr_ok}, 8'h00);
  endtask

  task automatic t_sr_write();
    do_wren();
    #1 chk("R5 sr_ok enabled", {7'd0, sr_wr_ok}, 8'h01);
    do_sr(8'hF7);
    chk("R7 R9 busy with old code", status_byte, 8'h03);
    #1 chk("R7 sr_ok while busy", {7'd0, sr_wr_ok}, 8'h00);
    do_done();
    chk("R8 R9 code 01 committed, others ignored", status_byte, 8'h04);
  endtask

  task automatic t_regions();
    do_wren();
    probe(9'h17F, 1, "R5 code01 below 0x180");
    probe(9'h180, 0, "R5 code01 at 0x180");
    do_wrdi();
    set_bp(8'h08);
    chk("R9 code 10 committed", status_byte, 8'h08);
    do_wren();
    probe(9'h0FF, 1, "R5 code10 at 0x0FF");
    probe(9'h100, 0, "R5 code10 at 0x100");
    do_wrdi();
    set_bp(8'h0C);
    do_wren();
    chk("R3 wren with code 11", status_byte, 8'h0E);
    probe(9'h000, 0, "R5 code11 at 0x000");
    #1 chk("R5 sr_ok with code 11", {7'd0, sr_wr_ok}, 8'h01);
    do_arr(9'h000);
    chk("R8 denied write keeps latch", status_byte, 8'h0E);
    do_sr(8'hF3); do_done();
    chk("R9 code 00 committed", status_byte, 8'h00);
    do_wren();
    probe(9'h1FF, 1, "R5 code00 at 0x1FF");
    do_wrdi();
  endtask

  task automatic t_arr_write();
    do_wren(); do_arr(9'h1FF);
    chk("R7 array write sets busy", status_byte, 8'h03);
    do_sr(8'h0C);
    do_done();
    chk("R7 R8 request during busy ignored, done clears", status_byte, 8'h00);
  endtask

  task automatic t_wp();
    do_wren();
    @(negedge clk) wp_n = 0; #1
    chk("R4 arr_ok with pin low", {7'd0, arr_wr_ok}, 8'h00);
    chk("R4 sr_ok with pin low", {7'd0, sr_wr_ok}, 8'h00);
    @(negedge clk) chk("R4 pin low clears latch", status_byte, 8'h00);
    do_wren(); chk("R4 wren ignored while pin low", status_byte, 8'h00);
    @(negedge clk) wp_n = 1;
  endtask

  task automatic t_wp_mid_cycle();
    do_wren(); do_sr(8'h04);
    @(negedge clk) wp_n = 0;
    @(negedge clk) chk("R10 busy holds after pin drop", status_byte, 8'h01);
    do_done();
    chk("R10 code committed despite pin", status_byte, 8'h04);
    @(negedge clk) wp_n = 1;
    set_bp(8'h00);
  endtask

  task automatic t_same_clock();
    @(negedge clk) wren_evt = 1; arr_req = 1; arr_addr = 9'h000;
    @(negedge clk) wren_evt = 0; arr_req = 0;
    chk("R11 same-clock enable does not start write", status_byte, 8'h02);
    do_wrdi();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_sr_write();
    t_regions();
    t_arr_write();
    t_wp();
    t_wp_mid_cycle();
    t_same_clock();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule